// File: doc/BRIEF.md
# Event Flag Interrupt Pin Controller

This block gathers three event strobes: a watchdog time-out, an alarm match and a power-fail warning. Each strobe lasts one clock cycle, and the block latches it into a sticky flag. The flags drive one shared interrupt pin. A host sees the block through a small register port. One register sets the interrupt behaviour. A second register holds the flags and empties itself when the host reads it. The host can watch the pin, or it can poll the flags register and leave every interrupt disabled.

The configuration register holds five settings:
- an enable for each of the three sources;
- the pin polarity, which also picks the drive style: active-high push-pull, or active-low open-drain;
- the pin mode: a timed pulse, or a level held until the flags are read.

The pin leaves the block as a data value and an output-enable. The pulse length is a cycle-count parameter. It defaults to 200 ms at a 200 MHz clock.

Top module: `evint_ctrl`

## Requirements
- R1: After reset both registers read 00h. With polarity 0, the pin is released (output-enable 0, data 0).
- R2: A strobe on any source sets its flag whether or not that source is enabled. The flags register bits are: bit 2 watchdog, bit 1 alarm, bit 0 power fail.
- R3: Flags register reads (address 1) return the flags in bits 2..0 with bits 7..3 as 0. Such a read clears every flag at the end of the read cycle.
- R4: A strobe in the same cycle as a flags read is not in that read's data. Its flag is set afterwards, and if its source is enabled, the pin asserts.
- R5: The configuration register (address 0) stores write bits 7..3 as: watchdog enable (7), alarm enable (6), power-fail enable (5), polarity (4) and pulse mode (3). Bits 2..0 read as 0.
- R6: A strobe from a source whose enable is 0 leaves the pin unchanged.
- R7: In level mode (bit 3 = 0), an enabled strobe asserts the pin from the next cycle. The pin stays asserted until a flags read.
- R8: In pulse mode (bit 3 = 1), an enabled strobe asserts the pin for exactly PULSE_CYCLES cycles. A flags read inside that window ends the pulse at once.
- R9: An enabled strobe that arrives during a running pulse restarts the full PULSE_CYCLES window.
- R10: With polarity 1, the output-enable is always 1 and the data equals the asserted state. With polarity 0, the data is always 0 and the output-enable is 1 only while the interrupt is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; a read at address 1 clears the flags |
| host_addr | input | 1 | 0 = configuration, 1 = flags |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register, valid in the read cycle |
| wdog_evt | input | 1 | Watchdog time-out strobe |
| alarm_evt | input | 1 | Alarm match strobe |
| pwrfail_evt | input | 1 | Power-fail strobe |
| irq_pin_o | output | 1 | Interrupt pin data value |
| irq_pin_oe | output | 1 | Interrupt pin output-enable |

## Verification
The hardest case to reach from the ports is a strobe and a flags read that land in the same clock cycle. The read must return the old flags, and the new flag and pin assertion must both survive the clear. The bench drives the strobe and the read strobe from one task, in the same cycle. It checks the read data through the scoreboard, then checks the pin state and a second read. Pulse retriggering is reached by firing a second enabled strobe halfway through a running pulse. The bench then counts cycles from that second strobe to the pin's release.

// File: rtl/evint_pkg.sv
package evint_pkg;

  localparam int REG_W   = 8;
  localparam int NUM_SRC = 3;

  // register addresses
  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_FLG = 1'b1;

  // source index inside the flag / enable vectors
  localparam int SRC_WDOG  = 2;
  localparam int SRC_ALARM = 1;
  localparam int SRC_PWR   = 0;

  // configuration register, stored in host bits 7..3
  typedef struct packed {
    logic wdog_en;    // bit 7
    logic alarm_en;   // bit 6
    logic pwr_en;     // bit 5
    logic pol_high;   // bit 4
    logic pulse_mode; // bit 3
  } cfg_t;

  localparam int CFG_W   = $bits(cfg_t);
  localparam int CFG_LSB = REG_W - CFG_W;

endpackage

// File: rtl/evint_regs.sv
module evint_regs
  import evint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_addr,
  input  logic [REG_W-1:0] host_wdata,
  input  logic [NUM_SRC-1:0] flags,
  output cfg_t             cfg,
  output logic             flags_clr,
  output logic [REG_W-1:0] host_rdata
);

  cfg_t cfg_q, cfg_d;
  logic cfg_we;
  logic [CFG_LSB-1:0] wdata_unused;

  assign wdata_unused = host_wdata[CFG_LSB-1:0];
  assign cfg_we       = host_wr && (host_addr == ADDR_CFG);
  assign flags_clr    = host_rd && (host_addr == ADDR_FLG);

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_t'(host_wdata[REG_W-1:CFG_LSB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  always_comb begin
    if (host_addr == ADDR_CFG) host_rdata = {cfg_q, {CFG_LSB{1'b0}}};
    else                       host_rdata = {{(REG_W-NUM_SRC){1'b0}}, flags};
  end

  assign cfg = cfg_q;

  assert_cfg_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(host_wdata[REG_W-1:CFG_LSB])));

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/evint_flags.sv
module evint_flags
  import evint_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr,
  output logic [NUM_SRC-1:0] flags
);

  logic [NUM_SRC-1:0] flags_q, flags_d;

  // set wins over clear so a strobe coinciding with a read survives
  always_comb begin
    flags_d = flags_q;
    if (clr) flags_d = '0;
    flags_d = flags_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags_q[i]);
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr) |=> flags_q[i]);
  end

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (evt == '0)) |=> (flags_q == '0));

endmodule

// File: rtl/evint_irq_timer.sv
module evint_irq_timer #(
  parameter int PULSE_CYCLES = 40_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic clr,
  input  logic pulse_mode,
  output logic active
);

  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = trig || clr || act_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (trig) begin
      act_d = 1'b1;
      cnt_d = CNT_LOAD;
    end else if (clr) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_q && pulse_mode) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;

  assert_trig_asserts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (act_q && (cnt_q == CNT_LOAD)));

  assert_level_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(clr) || $past(pulse_mode)));

  assert_pulse_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(clr) || ($past(cnt_q) == '0)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);

endmodule

// File: rtl/evint_pin.sv
module evint_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_high,
  input  logic active,
  output logic pin_o,
  output logic pin_oe
);

  always_comb begin
    if (pol_high) begin
      pin_o  = active;
      pin_oe = 1'b1;
    end else begin
      pin_o  = 1'b0;
      pin_oe = active;
    end
  end

  assert_od_never_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_high |-> !pin_o);

  assert_pp_always_driven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pol_high |-> pin_oe);

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!pin_o && (pin_oe == pol_high)));

endmodule

// File: rtl/evint_ctrl.sv
module evint_ctrl
  import evint_pkg::*;
#(
  parameter int PULSE_CYCLES = 40_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             wdog_evt,
  input  logic             alarm_evt,
  input  logic             pwrfail_evt,
  output logic             irq_pin_o,
  output logic             irq_pin_oe
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SRC-1:0] evt_vec, en_vec, flags;
  cfg_t cfg;
  logic flags_clr, trig, active;

  assign evt_vec[SRC_WDOG]  = wdog_evt;
  assign evt_vec[SRC_ALARM] = alarm_evt;
  assign evt_vec[SRC_PWR]   = pwrfail_evt;

  assign en_vec[SRC_WDOG]   = cfg.wdog_en;
  assign en_vec[SRC_ALARM]  = cfg.alarm_en;
  assign en_vec[SRC_PWR]    = cfg.pwr_en;

  assign trig = |(evt_vec & en_vec);

  evint_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .flags      (flags),
    .cfg        (cfg),
    .flags_clr  (flags_clr),
    .host_rdata (host_rdata)
  );

  evint_flags u_flags (
    .clk   (clk),
    .rst_n (rst_int_n),
    .evt   (evt_vec),
    .clr   (flags_clr),
    .flags (flags)
  );

  evint_irq_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .trig       (trig),
    .clr        (flags_clr),
    .pulse_mode (cfg.pulse_mode),
    .active     (active)
  );

  evint_pin u_pin (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pol_high (cfg.pol_high),
    .active   (active),
    .pin_o    (irq_pin_o),
    .pin_oe   (irq_pin_oe)
  );

  assert_disabled_no_pin_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!active && !trig) |=> !active);

  assert_pin_only_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(active) |-> (flags != '0));

endmodule

// File: tb/evint_ctrl_bench.sv
module evint_ctrl_bench;

  localparam int PULSE = 16;

  logic       clk, rst_n;
  logic       host_wr, host_rd, host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       wdog_evt, alarm_evt, pwrfail_evt;
  logic       irq_pin_o, irq_pin_oe;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } sb_item_t;

  sb_item_t sb_q[$];

  evint_ctrl #(.PULSE_CYCLES(PULSE)) u_evint_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wdog_evt(wdog_evt), .alarm_evt(alarm_evt), .pwrfail_evt(pwrfail_evt),
    .irq_pin_o(irq_pin_o), .irq_pin_oe(irq_pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: compare read data in the read cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && host_rd) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, actual %02h expected none", host_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (host_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: read actual %02h expected %02h", it.req, host_rdata, it.exp);
        end
      end
    end
  end

  // all tasks start and end 1 ns after a rising edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic do_write(input logic a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic do_read(input logic a, input logic [7:0] exp, input string req);
    sb_q.push_back('{exp: exp, req: req});
    host_rd = 1'b1; host_addr = a;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic fire(input logic [2:0] m);
    {wdog_evt, alarm_evt, pwrfail_evt} = m;
    @(posedge clk); #1;
    {wdog_evt, alarm_evt, pwrfail_evt} = 3'b000;
  endtask

  task automatic fire_read(input logic [2:0] m, input logic [7:0] exp, input string req);
    sb_q.push_back('{exp: exp, req: req});
    {wdog_evt, alarm_evt, pwrfail_evt} = m;
    host_rd = 1'b1; host_addr = 1'b1;
    @(posedge clk); #1;
    {wdog_evt, alarm_evt, pwrfail_evt} = 3'b000;
    host_rd = 1'b0;
  endtask

  task automatic check_pin(input logic ed, input logic eoe, input string req);
    checks++;
    if (irq_pin_o !== ed || irq_pin_oe !== eoe) begin
      errors++;
      $display("FAIL %s: pin actual o=%b oe=%b expected o=%b oe=%b",
               req, irq_pin_o, irq_pin_oe, ed, eoe);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_addr = 1'b0;
    host_wdata = '0; wdog_evt = 1'b0; alarm_evt = 1'b0; pwrfail_evt = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check_pin(1'b0, 1'b0, "R1");
    do_read(1'b0, 8'h00, "R1 cfg");
    do_read(1'b1, 8'h00, "R1 flags");

    // R5 config layout
    do_write(1'b0, 8'hFF);
    do_read(1'b0, 8'hF8, "R5 low bits zero");
    do_write(1'b0, 8'hA0);
    do_read(1'b0, 8'hA0, "R5 pattern");
    do_write(1'b0, 8'h00);

    // R2/R6 disabled source sets flag only; R3 clear on read
    fire(3'b100);
    check_pin(1'b0, 1'b0, "R6 disabled");
    do_read(1'b1, 8'h04, "R2 wdog flag");
    do_read(1'b1, 8'h00, "R3 cleared");
    fire(3'b111);
    do_read(1'b1, 8'h07, "R2 all flags");
    do_read(1'b1, 8'h00, "R3 cleared all");

    // R7 level mode, push-pull, only alarm enabled
    do_write(1'b0, 8'h50);
    check_pin(1'b0, 1'b1, "R10 pp idle");
    fire(3'b100);
    check_pin(1'b0, 1'b1, "R6 wdog disabled");
    fire(3'b010);
    check_pin(1'b1, 1'b1, "R7 asserted");
    idle(40);
    check_pin(1'b1, 1'b1, "R7 held");
    do_read(1'b1, 8'h06, "R3 two flags");
    check_pin(1'b0, 1'b1, "R7 released by read");

    // R4 strobe in the same cycle as a flags read
    do_write(1'b0, 8'h70);
    fire_read(3'b001, 8'h00, "R4 old data");
    check_pin(1'b1, 1'b1, "R4 pin survives");
    do_read(1'b1, 8'h01, "R4 flag survives");
    check_pin(1'b0, 1'b1, "R4 released");

    // R8 pulse mode length
    do_write(1'b0, 8'h58);
    fire(3'b010);
    idle(PULSE - 1);
    check_pin(1'b1, 1'b1, "R8 last pulse cycle");
    idle(1);
    check_pin(1'b0, 1'b1, "R8 pulse over");
    do_read(1'b1, 8'h02, "R8 flag kept after pulse");

    // R8 early end by read
    fire(3'b010);
    idle(3);
    do_read(1'b1, 8'h02, "R8 early read");
    check_pin(1'b0, 1'b1, "R8 early end");

    // R9 retrigger
    fire(3'b010);
    idle(8);
    fire(3'b010);
    idle(PULSE - 1);
    check_pin(1'b1, 1'b1, "R9 extended");
    idle(1);
    check_pin(1'b0, 1'b1, "R9 end after restart");
    do_read(1'b1, 8'h02, "R9 flags");

    // R10 open-drain, pulse and level
    do_write(1'b0, 8'h48);
    check_pin(1'b0, 1'b0, "R10 od idle");
    fire(3'b010);
    check_pin(1'b0, 1'b1, "R10 od asserted");
    do_read(1'b1, 8'h02, "R10 flags");
    check_pin(1'b0, 1'b0, "R10 od released");
    do_write(1'b0, 8'h40);
    fire(3'b010);
    idle(5);
    check_pin(1'b0, 1'b1, "R10 od level");
    do_read(1'b1, 8'h02, "R10 level flags");
    check_pin(1'b0, 1'b0, "R10 od level released");

    idle(2);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule